// File: doc/BRIEF.md
# Fiber Link Monitor State Machine

This block decides whether an optical receive link is usable. It watches a digital level bit, which is already hysteresis-filtered by the analog comparator, and a strobe from the data slicer that pulses on every receive transition. The link counts as good only when the level is high and transitions keep arriving at short intervals. While the link is bad, the block holds the transmit data path, the receiver and the loopback path disabled, and it keeps the active-low link LED dark. The idle tone generator sits outside this block and keeps running.

When the link turns good, the block does not re-enable at once. It first runs a long qualification period measured on a slow tick. It then waits until the transmit input is idle and no receive data is present. Only then does it light the LED and open the three enables. Short dips of the level bit are filtered out. The filter needs twice as many consecutive low cycles to drop the level as it needs high cycles to raise it. All times are parameters counted in clock cycles or in ticks.

Top module: `fiber_link_mon`

## Requirements
- R1: After reset the block is in link fail: `link_led_n` is 1 and `tx_data_en`, `rx_en` and `lpbk_en` are 0.
- R2: When no `rx_edge` pulse arrives for `ACT_WIN` cycles, the link is treated as bad, and a link in pass drops to fail.
- R3: Once in pass, a low `lvl_ok` lasting fewer than 2*`LVL_ON` consecutive cycles leaves the link in pass. A low lasting 2*`LVL_ON` cycles or more sends it to fail within two further cycles.
- R4: The level is treated as adequate only after `lvl_ok` has been high for `LVL_ON` consecutive cycles. The drop time is twice this rise time.
- R5: When level and activity first become good, pass is not reached before `LVL_ON` + (`QUAL_TICKS`-1)*`TICK_DIV` cycles have passed. The qualification period lasts `QUAL_TICKS` ticks, with one tick every `TICK_DIV` cycles.
- R6: After qualification, pass is entered only in a cycle after one in which `tx_busy` and `rx_busy` were both 0. While either is 1, the link stays in fail.
- R7: Any loss of level or activity during qualification or the quiet wait returns the machine to fail and clears the qualification timer. The next attempt then takes the full time again.
- R8: In pass, `link_led_n` is 0 and all three enables are 1. In every other state, `link_led_n` is 1 and all three enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_ok | input | 1 | Received optical level above threshold |
| rx_edge | input | 1 | One-cycle pulse per receive transition from the slicer |
| tx_busy | input | 1 | Transmit input carries data (not idle) |
| rx_busy | input | 1 | Receive data is present |
| link_led_n | output | 1 | Link LED, active low, on in pass |
| tx_data_en | output | 1 | Gates the transmit data path |
| rx_en | output | 1 | Enables the receiver |
| lpbk_en | output | 1 | Enables loopback |

## Verification
Some properties are checked on every cycle. The LED turns on only after a cycle in which both traffic indications were quiet. The LED is never on when the last transition lies further back than the activity window. The LED is never on when the level has been low for longer than the drop filter allows. The reset state is also checked. Other behaviour can only be shown by the bench scenarios: the lower bound on qualification time, the restart of the timer after a loss during qualification, the contrast between short and long level dips around the 2*`LVL_ON` boundary, and the blocking of pass by a busy transmit or receive side.

// File: rtl/flm_pkg.sv
package flm_pkg;

    typedef enum logic [1:0] {
        LNK_FAIL  = 2'd0,
        LNK_QUAL  = 2'd1,
        LNK_QUIET = 2'd2,
        LNK_PASS  = 2'd3
    } link_st_t;

    typedef struct packed {
        logic led_n;
        logic tx_en;
        logic rx_en;
        logic lb_en;
    } link_out_t;

    function automatic link_out_t decode_out(link_st_t s);
        link_out_t o;
        o.led_n = (s != LNK_PASS);
        o.tx_en = (s == LNK_PASS);
        o.rx_en = (s == LNK_PASS);
        o.lb_en = (s == LNK_PASS);
        return o;
    endfunction

endpackage

// File: rtl/flm_level_filter.sv
module flm_level_filter #(
    parameter int ON_CYC = 150
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_in,
    output logic lvl_q
);
    localparam int OFF_CYC = 2 * ON_CYC;
    localparam int W       = $clog2(OFF_CYC + 1);

    logic [W-1:0] cnt;
    logic         at_lim;

    always_comb begin
        if (lvl_q) at_lim = (cnt == W'(OFF_CYC - 1));
        else       at_lim = (cnt == W'(ON_CYC - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            cnt   <= '0;
        end else if (lvl_in == lvl_q) begin
            cnt <= '0;
        end else if (at_lim) begin
            lvl_q <= lvl_in;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/flm_activity.sv
module flm_activity #(
    parameter int WIN = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_in,
    output logic active
);
    localparam int W = $clog2(WIN + 1);

    logic [W-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap    <= W'(WIN - 1);
            active <= 1'b0;
        end else if (edge_in) begin
            gap    <= '0;
            active <= 1'b1;
        end else if (gap == W'(WIN - 1)) begin
            active <= 1'b0;
        end else begin
            gap <= gap + 1'b1;
        end
    end
endmodule

// File: rtl/flm_tick.sv
module flm_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = $clog2(DIV + 1);

    logic [W-1:0] cnt;

    assign tick = (cnt == W'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fiber_link_mon.sv
module fiber_link_mon #(
    parameter int TICK_DIV   = 100,
    parameter int ACT_WIN    = 300,
    parameter int LVL_ON     = 150,
    parameter int QUAL_TICKS = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_ok,
    input  logic rx_edge,
    input  logic tx_busy,
    input  logic rx_busy,
    output logic link_led_n,
    output logic tx_data_en,
    output logic rx_en,
    output logic lpbk_en
);
    import flm_pkg::*;

    localparam int QW = $clog2(QUAL_TICKS + 1);

    logic          lvl_q;
    logic          active;
    logic          tick;
    logic          good;
    logic [QW-1:0] qcnt;
    link_st_t      st;
    link_out_t     outs;

    flm_level_filter #(.ON_CYC(LVL_ON)) u_lvl (
        .clk(clk), .rst(rst), .lvl_in(lvl_ok), .lvl_q(lvl_q)
    );

    flm_activity #(.WIN(ACT_WIN)) u_act (
        .clk(clk), .rst(rst), .edge_in(rx_edge), .active(active)
    );

    flm_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    assign good = lvl_q & active;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LNK_FAIL;
            qcnt <= '0;
        end else begin
            case (st)
                LNK_FAIL: begin
                    qcnt <= '0;
                    if (good) st <= LNK_QUAL;
                end
                LNK_QUAL: begin
                    if (!good) begin
                        st   <= LNK_FAIL;
                        qcnt <= '0;
                    end else if (tick) begin
                        if (qcnt == QW'(QUAL_TICKS - 1)) begin
                            st   <= LNK_QUIET;
                            qcnt <= '0;
                        end else begin
                            qcnt <= qcnt + 1'b1;
                        end
                    end
                end
                LNK_QUIET: begin
                    if (!good)                     st <= LNK_FAIL;
                    else if (!tx_busy && !rx_busy) st <= LNK_PASS;
                end
                default: begin
                    if (!good) st <= LNK_FAIL;
                end
            endcase
        end
    end

    assign outs       = decode_out(st);
    assign link_led_n = outs.led_n;
    assign tx_data_en = outs.tx_en;
    assign rx_en      = outs.rx_en;
    assign lpbk_en    = outs.lb_en;
endmodule

// File: rtl/flm_checker.sv
module flm_checker #(
    parameter int ACT_WIN = 300,
    parameter int LVL_ON  = 150
) (
    input logic clk,
    input logic rst,
    input logic lvl_ok,
    input logic rx_edge,
    input logic tx_busy,
    input logic rx_busy,
    input logic link_led_n,
    input logic tx_data_en,
    input logic rx_en,
    input logic lpbk_en
);
    localparam int AW = $clog2(ACT_WIN + 4) + 1;
    localparam int LW = $clog2(2 * LVL_ON + 4) + 1;

    logic [AW-1:0] since_edge;
    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_edge <= AW'(ACT_WIN + 3);
            low_run    <= '0;
        end else begin
            if (rx_edge)                          since_edge <= '0;
            else if (since_edge != AW'(ACT_WIN + 3)) since_edge <= since_edge + 1'b1;
            if (lvl_ok)                           low_run <= '0;
            else if (low_run != LW'(2 * LVL_ON + 3)) low_run <= low_run + 1'b1;
        end
    end

    assert_reset_fail_R1: assert property (@(posedge clk)
        rst |=> (link_led_n && !tx_data_en && !rx_en && !lpbk_en));

    assert_pass_needs_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(link_led_n) |-> $past(!tx_busy && !rx_busy));

    assert_pass_needs_edges_R2: assert property (@(posedge clk) disable iff (rst)
        !link_led_n |-> (since_edge <= AW'(ACT_WIN + 1)));

    assert_pass_needs_level_R3: assert property (@(posedge clk) disable iff (rst)
        !link_led_n |-> (low_run <= LW'(2 * LVL_ON + 1)));
endmodule

bind fiber_link_mon flm_checker #(.ACT_WIN(ACT_WIN), .LVL_ON(LVL_ON)) u_flm_chk (
    .clk(clk), .rst(rst), .lvl_ok(lvl_ok), .rx_edge(rx_edge),
    .tx_busy(tx_busy), .rx_busy(rx_busy), .link_led_n(link_led_n),
    .tx_data_en(tx_data_en), .rx_en(rx_en), .lpbk_en(lpbk_en)
);

// File: tb/sim_fiber_link_mon.sv
module sim_fiber_link_mon;
    localparam int TICK_DIV   = 4;
    localparam int ACT_WIN    = 20;
    localparam int LVL_ON     = 5;
    localparam int QUAL_TICKS = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lvl_ok = 1'b0;
    logic rx_edge;
    logic tx_busy = 1'b0;
    logic rx_busy = 1'b0;
    logic link_led_n, tx_data_en, rx_en, lpbk_en;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    bit  edges_on = 0;
    int  period = 8;
    int  ecnt = 0;

    always #5 clk = ~clk;

    fiber_link_mon #(
        .TICK_DIV(TICK_DIV), .ACT_WIN(ACT_WIN),
        .LVL_ON(LVL_ON), .QUAL_TICKS(QUAL_TICKS)
    ) u0 (
        .clk(clk), .rst(rst), .lvl_ok(lvl_ok), .rx_edge(rx_edge),
        .tx_busy(tx_busy), .rx_busy(rx_busy), .link_led_n(link_led_n),
        .tx_data_en(tx_data_en), .rx_en(rx_en), .lpbk_en(lpbk_en)
    );

    always @(negedge clk) begin
        if (edges_on) begin
            ecnt    <= ecnt + 1;
            rx_edge <= ((ecnt + 1) % period == 0);
        end else begin
            rx_edge <= 1'b0;
        end
    end

    function automatic bit exp_drop(int len);
        return len >= 2 * LVL_ON;
    endfunction

    function automatic int min_pass_cycles();
        return LVL_ON + (QUAL_TICKS - 1) * TICK_DIV;
    endfunction

    function automatic int max_pass_cycles(int per);
        return per + LVL_ON + QUAL_TICKS * TICK_DIV + 6;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        bit saw_fail;
        void'($urandom(32'd4242));
        cyc(3);
        // R1 reset state
        chk("R1 led", link_led_n, 1'b1);
        chk("R1 tx_en", tx_data_en, 1'b0);
        chk("R1 rx_en", rx_en, 1'b0);
        chk("R1 lb_en", lpbk_en, 1'b0);
        rst = 1'b0;

        // R5/R6: qualification delay and quiet wait
        period = 8; tx_busy = 1'b1; lvl_ok = 1'b1; edges_on = 1;
        cyc(min_pass_cycles() - 5);
        chk("R5 still qualifying", link_led_n, 1'b1);
        cyc(max_pass_cycles(period) - min_pass_cycles() + 10);
        chk("R6 tx busy blocks pass", link_led_n, 1'b1);
        tx_busy = 1'b0; rx_busy = 1'b1;
        cyc(5);
        chk("R6 rx busy blocks pass", link_led_n, 1'b1);
        rx_busy = 1'b0;
        cyc(3);
        chk("R8 led on in pass", link_led_n, 1'b0);
        chk("R8 tx_en in pass", tx_data_en, 1'b1);
        chk("R8 rx_en in pass", rx_en, 1'b1);
        chk("R8 lb_en in pass", lpbk_en, 1'b1);

        // R3/R4: short dip ignored, long dip drops
        saw_fail = 0;
        lvl_ok = 1'b0;
        repeat (2 * LVL_ON - 2) begin @(negedge clk); if (link_led_n) saw_fail = 1; end
        lvl_ok = 1'b1;
        repeat (4) begin @(negedge clk); if (link_led_n) saw_fail = 1; end
        chk("R3 short dip ignored", saw_fail, 1'b0);
        lvl_ok = 1'b0;
        cyc(LVL_ON + 3);
        chk("R4 drop takes twice rise time", link_led_n, 1'b0);
        cyc(LVL_ON + 4);
        chk("R3 long dip fails", link_led_n, 1'b1);
        chk("R8 tx_en off in fail", tx_data_en, 1'b0);

        // R2: activity loss
        lvl_ok = 1'b1;
        cyc(max_pass_cycles(period) + 10);
        chk("R5 recovered to pass", link_led_n, 1'b0);
        edges_on = 0;
        cyc(5);
        chk("R2 still active shortly after last edge", link_led_n, 1'b0);
        cyc(ACT_WIN + 10);
        chk("R2 no edges fails link", link_led_n, 1'b1);

        // R7: loss during qualification restarts timer
        edges_on = 1;
        cyc(period + LVL_ON + 2 * TICK_DIV);
        lvl_ok = 1'b0;
        cyc(2 * LVL_ON + 2);
        lvl_ok = 1'b1;
        cyc(min_pass_cycles() - 3);
        chk("R7 timer restarted", link_led_n, 1'b1);
        cyc(max_pass_cycles(period));
        chk("R7 pass after full requal", link_led_n, 1'b0);

        // random dips with random edge spacing
        for (int i = 0; i < 10; i++) begin
            int len;
            period = $urandom_range(2, 12);
            lvl_ok = 1'b1; edges_on = 1;
            cyc(max_pass_cycles(12) + 20);
            chk("R5 random pass", link_led_n, 1'b0);
            len = $urandom_range(1, 3 * LVL_ON);
            saw_fail = 0;
            lvl_ok = 1'b0;
            repeat (len) begin @(negedge clk); if (link_led_n) saw_fail = 1; end
            lvl_ok = 1'b1;
            repeat (3) begin @(negedge clk); if (link_led_n) saw_fail = 1; end
            chk("R3 random dip", saw_fail, exp_drop(len));
        end

        done = 1;
        summary();
        $finish;
    end
endmodule